// File: doc/BRIEF.md
# Multiplexed Address/Data Bus with Memory and I/O Decode

This block joins one bus master and two targets over a shared 8-bit line set that carries an address and then data, one after the other. A local request (read or write, 8-bit address, 8-bit write data) is taken by the master only while it is idle. The master then drives one address cycle with the address-valid strobe raised. It follows with a data phase in which a read or a write strobe is held.

Every target captures the address while address-valid is high and decides whether it owns it. The top address bit chooses between a 128-word memory target and an I/O register target. The low seven bits give the word or port number. The I/O target implements the ports below `IO_PORTS` (96 by default). The ports above that are unclaimed, so an access to one of them runs into the master's acknowledge timeout. The bus is modelled as a driven multiplexer: in any cycle only one source drives it, and otherwise it reads zero.

Top module: `mux_ad_bus`

## Requirements
- R1: While reset is held, and in every idle cycle after it, bus_ad, bus_av, bus_rd, bus_wr, bus_ack, rsp_done and rsp_err are all 0.
- R2: A request seen at a clock edge while idle produces, in the next cycle, exactly one cycle with bus_av=1 and bus_ad equal to the request address, with both strobes low.
- R3: The data phase starts in the cycle after the address cycle. bus_wr (write) or bus_rd (read) is high in every data cycle. For a write, bus_ad carries the write data in every data cycle.
- R4: Address bit 7 = 0 selects memory word addr[6:0]. Bit 7 = 1 selects I/O port addr[6:0], which is present only when addr[6:0] < 96. Memory and I/O storage are separate, so the same low bits reach different locations.
- R5: A selected target acknowledges with a single-cycle bus_ack in the second data cycle. On a read, the stored byte is on bus_ad in that cycle, and bus_ad is 0 in the first data cycle of a read.
- R6: rsp_done pulses for one cycle, in the cycle after the acknowledge. rsp_rdata then holds the byte read and keeps it until the next successful read.
- R7: When no target claims the address, the strobe stays high for 4 data cycles with no bus_ack and bus_ad at 0 on a read. rsp_done and rsp_err then pulse together in the next cycle, and rsp_rdata is unchanged.
- R8: A request raised while a transfer is in progress is ignored. It is taken only at an edge where the master is idle, which includes the edge that ends the done cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Bus address, bit 7 chooses I/O |
| req_wdata | input | 8 | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Timeout flag, valid with rsp_done |
| rsp_rdata | output | 8 | Last successfully read byte |
| bus_ad | output | 8 | Shared address/data lines |
| bus_av | output | 1 | Address valid strobe |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_ack | output | 1 | Target acknowledge |

## Verification
Counting from the edge that takes a request, address-valid is due one cycle later and the first strobe two cycles later. The acknowledge with the read byte is due three cycles later, and done four cycles later. A timed-out access gives done with error six cycles after the request edge. The bench keeps a behavioural step counter that advances at each rising edge from the sampled request, and it derives every expected bus line and response from that counter and from byte arrays of its own. It compares all outputs at each falling edge, after the registers have settled, so each result is checked in exactly the cycle it is due. Directed cases cover both targets with aliased low bits, the last present port, an unclaimed port for both read and write, and a request held high through a transfer.

// File: rtl/mux_ad_bus.sv
module mux_ad_bus #(
  parameter int BUS_W     = 8,
  parameter int IO_PORTS  = 96,
  parameter int ACK_LIMIT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [BUS_W-1:0] req_addr,
  input  logic [BUS_W-1:0] req_wdata,
  output logic             rsp_done,
  output logic             rsp_err,
  output logic [BUS_W-1:0] rsp_rdata,
  output logic [BUS_W-1:0] bus_ad,
  output logic             bus_av,
  output logic             bus_rd,
  output logic             bus_wr,
  output logic             bus_ack
);
  localparam int IDX_W = BUS_W - 1;
  localparam int DEPTH = 1 << IDX_W;
  localparam int CW    = $clog2(ACK_LIMIT + 1);

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_DATA} st_t;

  st_t              st;
  logic [BUS_W-1:0] a_q, wd_q;
  logic             we_q;
  logic [CW-1:0]    cnt;

  // master sequencer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; a_q <= '0; wd_q <= '0; we_q <= 1'b0; cnt <= '0;
      rsp_done <= 1'b0; rsp_err <= 1'b0; rsp_rdata <= '0;
    end else begin
      rsp_done <= 1'b0;
      rsp_err  <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          a_q <= req_addr; wd_q <= req_wdata; we_q <= req_write; st <= S_ADDR;
        end
        S_ADDR: begin st <= S_DATA; cnt <= '0; end
        S_DATA: begin
          if (bus_ack) begin
            rsp_done <= 1'b1;
            if (!we_q) rsp_rdata <= bus_ad;
            st <= S_IDLE;
          end else if (cnt == CW'(ACK_LIMIT - 1)) begin
            rsp_done <= 1'b1; rsp_err <= 1'b1; st <= S_IDLE;
          end else cnt <= cnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign bus_av = (st == S_ADDR);
  assign bus_rd = (st == S_DATA) && !we_q;
  assign bus_wr = (st == S_DATA) && we_q;

  // targets: address latch and decode
  logic [IDX_W-1:0] tgt_a;
  logic             mem_sel, io_sel, mem_ack, io_ack;
  logic             port_ok;
  assign port_ok = 32'(bus_ad[IDX_W-1:0]) < IO_PORTS;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tgt_a <= '0; mem_sel <= 1'b0; io_sel <= 1'b0; mem_ack <= 1'b0; io_ack <= 1'b0;
    end else begin
      if (bus_av) begin
        tgt_a   <= bus_ad[IDX_W-1:0];
        mem_sel <= !bus_ad[BUS_W-1];
        io_sel  <= bus_ad[BUS_W-1] && port_ok;
      end
      mem_ack <= mem_sel && (bus_rd || bus_wr) && !mem_ack;
      io_ack  <= io_sel  && (bus_rd || bus_wr) && !io_ack;
    end
  end

  logic [BUS_W-1:0] mem    [DEPTH];
  logic [BUS_W-1:0] io_reg [IO_PORTS];

  always_ff @(posedge clk) begin
    if (bus_wr && mem_sel && !mem_ack) mem[tgt_a] <= bus_ad;
    if (bus_wr && io_sel && !io_ack)   io_reg[tgt_a] <= bus_ad;
  end

  logic [BUS_W-1:0] mem_q, io_q;
  assign mem_q   = mem[tgt_a];
  assign io_q    = io_sel ? io_reg[tgt_a] : '0;
  assign bus_ack = mem_ack | io_ack;

  assign bus_ad = (st == S_ADDR)              ? a_q  :
                  (st == S_DATA && we_q)      ? wd_q :
                  (bus_rd && mem_sel && mem_ack) ? mem_q :
                  (bus_rd && io_sel && io_ack)   ? io_q  : '0;

  // R2
  av_single_chk: assert property (@(posedge clk) disable iff (!rst_n) bus_av |=> !bus_av);
  // R2
  av_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) bus_av |-> !bus_rd && !bus_wr);
  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(bus_rd && bus_wr));
  // R3
  data_follows_chk: assert property (@(posedge clk) disable iff (!rst_n) bus_av |=> (bus_rd || bus_wr));
  // R5
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) bus_ack |=> !bus_ack);
  // R6
  done_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n) bus_ack |=> rsp_done && !rsp_err);
  // R7
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n) rsp_err |-> rsp_done);
  // R4
  one_target_chk: assert property (@(posedge clk) disable iff (!rst_n) !(mem_ack && io_ack));
endmodule

// File: tb/mux_ad_bus_tb.sv
module mux_ad_bus_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [7:0] req_addr = '0, req_wdata = '0;
  logic rsp_done, rsp_err, bus_av, bus_rd, bus_wr, bus_ack;
  logic [7:0] rsp_rdata, bus_ad;

  always #2 clk = ~clk;

  mux_ad_bus dut_i (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_done(rsp_done), .rsp_err(rsp_err),
    .rsp_rdata(rsp_rdata), .bus_ad(bus_ad), .bus_av(bus_av), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_ack(bus_ack));

  int total = 0, bad = 0, cyc = 0;
  bit finished = 0;

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", tag, cyc, act, exp);
    end
  endtask

  // behavioural reference
  int k = -1, endk = 0;
  bit mw, hit;
  logic [7:0] ma, mwd, exp_rd = 8'h00;
  logic [7:0] mm [128];
  logic [7:0] mi [128];

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin k = -1; exp_rd = 8'h00; end
    else begin
      if (k >= 0 && k < endk) k++;
      else if (req_valid) begin
        k = 0; ma = req_addr; mw = req_write; mwd = req_wdata;
        hit = ma[7] ? (int'(ma[6:0]) < 96) : 1'b1;
        endk = hit ? 3 : 5;
      end else k = -1;
      if (k == 2 && hit && mw) begin
        if (ma[7]) mi[ma[6:0]] = mwd; else mm[ma[6:0]] = mwd;
      end
      if (k == 3 && hit && !mw) exp_rd = ma[7] ? mi[ma[6:0]] : mm[ma[6:0]];
    end
  end

  function automatic logic [7:0] stored();
    return ma[7] ? mi[ma[6:0]] : mm[ma[6:0]];
  endfunction

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      int dlast;
      bit indata;
      logic [7:0] ead;
      dlast  = hit ? 2 : 4;
      indata = (k >= 1 && k <= dlast);
      if (k < 0 || k > dlast) ead = 8'h00;
      else if (k == 0) ead = ma;
      else if (mw) ead = mwd;
      else if (hit && k == 2) ead = stored();
      else ead = 8'h00;
      check(k < 0 ? "R1 bus_av idle" : "R2 bus_av", bus_av, k == 0);
      check("R3 bus_rd", bus_rd, indata && !mw);
      check("R3 bus_wr", bus_wr, indata && mw);
      check(mw ? "R3 bus_ad" : (hit ? "R4/R5 bus_ad" : "R7 bus_ad"), bus_ad, ead);
      check("R5 bus_ack", bus_ack, hit && k == 2);
      check("R6 rsp_done", rsp_done, k == endk && k > 0);
      check("R7 rsp_err", rsp_err, !hit && k == 5);
      check("R6 rsp_rdata", rsp_rdata, exp_rd);
    end
  end

  task automatic xfer(input bit w, input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (7) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset bus_ad", bus_ad, 0);
    check("R1 reset strobes", {bus_av, bus_rd, bus_wr, bus_ack}, 0);
    check("R1 reset done/err", {rsp_done, rsp_err}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R4 aliasing low bits across memory and I/O
    xfer(1, 8'h05, 8'hA5);
    xfer(1, 8'h85, 8'h3C);
    xfer(0, 8'h05, 8'h00);
    check("R4 memory word 5", rsp_rdata, 8'hA5);
    xfer(0, 8'h85, 8'h00);
    check("R4 io port 5", rsp_rdata, 8'h3C);
    xfer(1, 8'h7F, 8'h81);
    xfer(1, 8'hDF, 8'h5E);
    xfer(0, 8'h7F, 8'h00);
    xfer(0, 8'hDF, 8'h00);
    check("R4 last io port", rsp_rdata, 8'h5E);
    // R7 unclaimed ports
    xfer(0, 8'hE0, 8'h00);
    check("R7 rdata kept", rsp_rdata, 8'h5E);
    xfer(1, 8'hFF, 8'h11);
    xfer(0, 8'h00, 8'h00);
    xfer(1, 8'h00, 8'h77);
    xfer(0, 8'h00, 8'h00);
    check("R6 rdata word 0", rsp_rdata, 8'h77);
    // R8 request held high across transfers, changing mid-flight
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 8'h05;
    repeat (2) @(negedge clk);
    req_addr = 8'h85;
    repeat (2) @(negedge clk);
    req_addr = 8'h7F;
    repeat (3) @(negedge clk);
    req_valid = 1'b0;
    repeat (10) @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule